// File: doc/BRIEF.md
# Proximity Interrupt Output Controller

This block turns a stream of 8-bit proximity samples into one active-low interrupt pin for a host processor. A 3-bit mode field chooses how the pin behaves. In comparator mode it works as a proximity switch with hysteresis: it is pulled low when a sample rises above a high threshold and released when a sample drops below a low threshold. In wake-up mode it latches low on the first sample above the high threshold and stays low until software moves the mode field away from wake-up. In data-ready mode it signals that a fresh sample is waiting and is released when the host starts reading the data register.

The serial register interface reports when a read of the data register starts and when the transfer ends. If a new sample arrives while such a read is running, the data-ready pin gives a short pulse of fixed length instead of a level, so the host never misses a conversion. Three status flags track the comparator state, the wake-up latch and data availability for a status register. These flags keep updating in every mode.

Top module: `prox_irq_ctrl`

## Requirements
- R1: Mode codes are 3'b001 wake-up, 3'b010 comparator and 3'b100 data-ready. Code 3'b000 and every reserved code (3'b011, 3'b101, 3'b110, 3'b111) hold `irq_n` high. The comparator state survives while such a code is selected.
- R2: In comparator mode, a sample taken with `smp_vld` high that is strictly greater than `thr_hi` drives `irq_n` low and `st_below` to 0 after the next clock edge. A sample equal to `thr_hi` does not assert the pin.
- R3: In comparator mode, a sample strictly less than `thr_lo` releases `irq_n` and sets `st_below` to 1. A sample equal to `thr_lo`, or between the two thresholds, leaves the state unchanged.
- R4: The comparator state resets to deasserted, so `st_below` reads 1 after reset.
- R5: In wake-up mode, a sample strictly above `thr_hi` drives `irq_n` low and `st_wake_n` to 0. Later samples below `thr_lo` do not release them.
- R6: The wake-up latch clears only when the mode field leaves 3'b001. Returning to wake-up mode without a new crossing keeps `irq_n` high and `st_wake_n` at 1.
- R7: A sample that arrives while no data-register read is running sets `st_ready_n` to 0 and, in data-ready mode, drives `irq_n` low. An `rd_start` clears both after the next clock edge.
- R8: A sample that arrives while a read is running (from the `rd_start` cycle until `rd_end`) leaves `st_ready_n` at 1. In data-ready mode it drives `irq_n` low for exactly `PULSE_CYC` clock cycles.
- R9: Sample values presented without `smp_vld` have no effect on any output.
- R10: Synchronous reset drives `irq_n`, `st_below`, `st_wake_n` and `st_ready_n` all to 1 and ends any pulse that is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp | input | 8 | Proximity sample value |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| thr_hi | input | 8 | High threshold |
| thr_lo | input | 8 | Low threshold |
| mode | input | 3 | Pin mode field |
| rd_start | input | 1 | A read of the data register has begun |
| rd_end | input | 1 | The read transfer has finished |
| irq_n | output | 1 | Interrupt pin, active low |
| st_below | output | 1 | 1 while the comparator is deasserted |
| st_wake_n | output | 1 | 0 once wake-up has triggered |
| st_ready_n | output | 1 | 0 while unread data is waiting |

## Verification
The bench keeps the 8-bit sample width and shortens `PULSE_CYC` to 3. With that setting the whole length of the strobe pulse can be checked cycle by cycle: low on each of the three cycles and high on the fourth. This includes the case where `rd_start` and the sample strobe land in the same cycle. The thresholds are held at 0x80 and 0x40, so samples equal to each threshold probe the strict comparisons directly.

// File: rtl/prox_irq_pkg.sv
// Shared types for the proximity interrupt controller.
// Assumes the mode field is exactly three bits wide, one-hot for the legal modes.
package prox_irq_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_OFF  = 3'b000,
        PM_WAKE = 3'b001,
        PM_CMP  = 3'b010,
        PM_DRDY = 3'b100
    } pin_mode_e;

    typedef struct packed {
        logic wake;
        logic cmp;
        logic drdy;
    } mode_sel_t;

endpackage

// File: rtl/prox_mode_dec.sv
// Decodes the raw mode field into one select line per legal mode.
// Assumes reserved codes must select nothing, so the pin falls back to idle.
module prox_mode_dec
    import prox_irq_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_sel_t         sel
);

    // Map each exact legal code to its select; every other code selects none.
    always_comb begin
        sel = '0;
        case (mode)
            PM_WAKE: sel.wake = 1'b1;
            PM_CMP:  sel.cmp  = 1'b1;
            PM_DRDY: sel.drdy = 1'b1;
            default: sel      = '0;
        endcase
    end

endmodule

// File: rtl/prox_hyst_cmp.sv
// Hysteretic threshold comparator on the sample stream.
// Assumes samples count only on strobe cycles and that comparisons are strict.
module prox_hyst_cmp #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    output logic              cmp_on
);

    logic above;
    logic below;

    // Strict crossings of each threshold.
    always_comb begin
        above = (smp > thr_hi);
        below = (smp < thr_lo);
    end

    // Set on an upward crossing, clear on a downward one, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_on <= 1'b0;
        end else if (smp_vld) begin
            if (above) begin
                cmp_on <= 1'b1;
            end else if (below) begin
                cmp_on <= 1'b0;
            end
        end
    end

    p_cmp_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && above |=> cmp_on);

    p_cmp_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && !above && below |=> !cmp_on);

    p_cmp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld || (!above && !below) |=> $stable(cmp_on));

endmodule

// File: rtl/prox_wake_latch.sv
// Sticky wake-up latch: sets on a high-threshold crossing while wake-up is selected.
// Assumes only leaving wake-up mode clears it; samples never clear it.
module prox_wake_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_en,
    input  logic [DATA_W-1:0] smp,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] thr_hi,
    output logic              wake_on
);

    // Clear whenever the mode is not wake-up, set on a crossing, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_on <= 1'b0;
        end else if (!wake_en) begin
            wake_on <= 1'b0;
        end else if (smp_vld && (smp > thr_hi)) begin
            wake_on <= 1'b1;
        end
    end

    p_wake_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_en && wake_on |=> wake_on);

    p_wake_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_en |=> !wake_on);

endmodule

// File: rtl/prox_drdy_gen.sv
// Data-ready tracker: holds a ready flag that a read acknowledges, and fires
// a fixed pulse when a sample lands during a running read.
// Assumes rd_start and rd_end are single-cycle marks from the register interface.
module prox_drdy_gen #(
    parameter int PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic rd_start,
    input  logic rd_end,
    output logic rdy_on,
    output logic pulse_on
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

    logic             busy_q;
    logic             in_read;
    logic [CNT_W-1:0] pcnt_q;

    // A read counts as running from its start cycle onward.
    always_comb in_read = busy_q || rd_start;

    // Track whether a data-register read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (rd_start) begin
            busy_q <= 1'b1;
        end else if (rd_end) begin
            busy_q <= 1'b0;
        end
    end

    // Ready flag: a sample outside a read sets it, the start of a read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_on <= 1'b0;
        end else if (rd_start) begin
            rdy_on <= 1'b0;
        end else if (smp_vld && !busy_q) begin
            rdy_on <= 1'b1;
        end
    end

    // Pulse counter: load on a sample during a read, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (smp_vld && in_read) begin
            pcnt_q <= CNT_LOAD;
        end else if (pcnt_q != '0) begin
            pcnt_q <= pcnt_q - 1'b1;
        end
    end

    always_comb pulse_on = (pcnt_q != '0);

    p_rdy_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rdy_on);

    p_pulse_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && in_read |=> pulse_on && !rdy_on);

    p_pulse_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= CNT_LOAD);

endmodule

// File: rtl/prox_irq_ctrl.sv
// Proximity interrupt output controller: merges comparator, wake-up latch
// and data-ready strobe onto one active-low pin, selected by the mode field.
// Assumes thresholds and mode are stable register values from the host side.
module prox_irq_ctrl
    import prox_irq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic [MODE_W-1:0] mode,
    input  logic              rd_start,
    input  logic              rd_end,
    output logic              irq_n,
    output logic              st_below,
    output logic              st_wake_n,
    output logic              st_ready_n
);

    mode_sel_t sel;
    logic      cmp_on;
    logic      wake_on;
    logic      rdy_on;
    logic      pulse_on;

    prox_mode_dec u_dec (
        .mode (mode),
        .sel  (sel)
    );

    prox_hyst_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (smp),
        .smp_vld (smp_vld),
        .thr_hi  (thr_hi),
        .thr_lo  (thr_lo),
        .cmp_on  (cmp_on)
    );

    prox_wake_latch #(.DATA_W(DATA_W)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake_en (sel.wake),
        .smp     (smp),
        .smp_vld (smp_vld),
        .thr_hi  (thr_hi),
        .wake_on (wake_on)
    );

    prox_drdy_gen #(.PULSE_CYC(PULSE_CYC)) u_drdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .rd_start (rd_start),
        .rd_end   (rd_end),
        .rdy_on   (rdy_on),
        .pulse_on (pulse_on)
    );

    // Pick the source that drives the pin; idle high when no mode is selected.
    always_comb begin
        irq_n = 1'b1;
        if (sel.cmp) begin
            irq_n = !cmp_on;
        end else if (sel.wake) begin
            irq_n = !wake_on;
        end else if (sel.drdy) begin
            irq_n = !(rdy_on || pulse_on);
        end
    end

    // Status flags in their register polarity.
    always_comb begin
        st_below   = !cmp_on;
        st_wake_n  = !wake_on;
        st_ready_n = !rdy_on;
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel.cmp || sel.wake || sel.drdy) |-> irq_n);

    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel.cmp, sel.wake, sel.drdy}));

    p_wake_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel.wake && !st_wake_n |-> !irq_n);

endmodule

// File: tb/prox_irq_ctrl_tb_top.sv
// Scoreboard bench: the driver pushes expected outputs per cycle, the monitor pops and compares.
module prox_irq_ctrl_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  PULSE      = 3;

    typedef struct {
        logic  irq_n;
        logic  below;
        logic  wake_n;
        logic  ready_n;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] smp;
    logic       smp_vld;
    logic [7:0] thr_hi;
    logic [7:0] thr_lo;
    logic [2:0] mode;
    logic       rd_start;
    logic       rd_end;
    logic       irq_n;
    logic       st_below;
    logic       st_wake_n;
    logic       st_ready_n;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    prox_irq_ctrl #(.DATA_W(8), .PULSE_CYC(PULSE)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp        (smp),
        .smp_vld    (smp_vld),
        .thr_hi     (thr_hi),
        .thr_lo     (thr_lo),
        .mode       (mode),
        .rd_start   (rd_start),
        .rd_end     (rd_end),
        .irq_n      (irq_n),
        .st_below   (st_below),
        .st_wake_n  (st_wake_n),
        .st_ready_n (st_ready_n)
    );

    // Driver: one cycle of stimulus plus the outputs expected after the next edge.
    task automatic step(input logic rs_n, input logic [2:0] md, input logic [7:0] s,
                        input logic v, input logic rs, input logic re,
                        input logic e_irq, input logic e_below, input logic e_wake_n,
                        input logic e_ready_n, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n    = rs_n;
        mode     = md;
        smp      = s;
        smp_vld  = v;
        rd_start = rs;
        rd_end   = re;
        e.irq_n   = e_irq;
        e.below   = e_below;
        e.wake_n  = e_wake_n;
        e.ready_n = e_ready_n;
        e.tag     = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: a quarter period after each edge, compare against the oldest entry.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (sb_q.size() > 0) begin
                exp_t e;
                logic [3:0] act;
                logic [3:0] exp_v;
                e     = sb_q.pop_front();
                act   = {irq_n, st_below, st_wake_n, st_ready_n};
                exp_v = {e.irq_n, e.below, e.wake_n, e.ready_n};
                checks++;
                if (act !== exp_v) begin
                    errors++;
                    $display("FAIL %s {irq_n,below,wake_n,ready_n} actual=%b expected=%b",
                             e.tag, act, exp_v);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000 && !done) begin
                errors++;
                $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; mode = 3'b000; smp = 8'h00; smp_vld = 1'b0;
        rd_start = 1'b0; rd_end = 1'b0;
        thr_hi = 8'h80; thr_lo = 8'h40;

        // R10: reset state
        step(0, 3'b000, 8'h00, 0, 0, 0, 1, 1, 1, 1, "R10 reset");
        step(1, 3'b000, 8'h00, 0, 0, 0, 1, 1, 1, 1, "R4 cmp reset deasserted");

        // Comparator mode: strict crossings and hold band
        step(1, 3'b010, 8'h80, 1, 0, 0, 1, 1, 1, 0, "R2 equal to high no assert");
        step(1, 3'b010, 8'h81, 1, 0, 0, 0, 0, 1, 0, "R2 above high asserts");
        step(1, 3'b010, 8'h40, 1, 0, 0, 0, 0, 1, 0, "R3 equal to low holds");
        step(1, 3'b010, 8'h00, 0, 0, 0, 0, 0, 1, 0, "R9 no strobe ignored");
        step(1, 3'b010, 8'h3F, 1, 0, 0, 1, 1, 1, 0, "R3 below low releases");
        step(1, 3'b010, 8'hFF, 0, 0, 0, 1, 1, 1, 0, "R9 high value without strobe ignored");
        step(1, 3'b010, 8'h70, 1, 0, 0, 1, 1, 1, 0, "R3 in band holds");
        step(1, 3'b010, 8'h00, 0, 1, 0, 1, 1, 1, 1, "R7 read start clears ready");
        step(1, 3'b010, 8'h00, 0, 0, 1, 1, 1, 1, 1, "R7 read end");

        // Reserved and off codes keep the pin high, comparator state kept
        step(1, 3'b010, 8'hFF, 1, 0, 0, 0, 0, 1, 0, "R2 assert before reserved test");
        step(1, 3'b011, 8'h00, 0, 0, 0, 1, 0, 1, 0, "R1 code 011 idle");
        step(1, 3'b101, 8'h00, 0, 0, 0, 1, 0, 1, 0, "R1 code 101 idle");
        step(1, 3'b110, 8'h00, 0, 0, 0, 1, 0, 1, 0, "R1 code 110 idle");
        step(1, 3'b111, 8'h00, 0, 0, 0, 1, 0, 1, 0, "R1 code 111 idle");
        step(1, 3'b000, 8'h00, 0, 0, 0, 1, 0, 1, 0, "R1 code 000 idle");
        step(1, 3'b010, 8'h00, 0, 0, 0, 0, 0, 1, 0, "R1 comparator state kept");

        // Wake-up mode: strict set, sticky against low samples
        step(1, 3'b001, 8'h00, 0, 0, 0, 1, 0, 1, 0, "R6 enter wake no trigger");
        step(1, 3'b001, 8'h80, 1, 0, 0, 1, 0, 1, 0, "R5 equal to high no wake");
        step(1, 3'b001, 8'h90, 1, 0, 0, 0, 0, 0, 0, "R5 wake triggers");
        step(1, 3'b001, 8'h10, 1, 0, 0, 0, 1, 0, 0, "R5 wake sticky below low");
        step(1, 3'b001, 8'h00, 0, 0, 0, 0, 1, 0, 0, "R5 wake stays");
        step(1, 3'b010, 8'h00, 0, 0, 0, 1, 1, 1, 0, "R6 leaving wake clears");
        step(1, 3'b001, 8'h00, 0, 0, 0, 1, 1, 1, 0, "R6 re-enter wake stays clear");

        // Data-ready mode: level and acknowledge
        step(1, 3'b100, 8'h00, 0, 0, 0, 0, 1, 1, 0, "R7 pending data shows low");
        step(1, 3'b100, 8'h00, 0, 1, 0, 1, 1, 1, 1, "R7 read start releases");
        step(1, 3'b100, 8'h00, 0, 0, 1, 1, 1, 1, 1, "R7 read end");
        step(1, 3'b100, 8'h10, 1, 0, 0, 0, 1, 1, 0, "R7 new sample asserts");
        step(1, 3'b100, 8'h00, 0, 0, 0, 0, 1, 1, 0, "R7 level holds");
        step(1, 3'b100, 8'h00, 0, 1, 0, 1, 1, 1, 1, "R7 read acknowledges");

        // Sample during a running read: exact pulse length
        step(1, 3'b100, 8'h10, 1, 0, 0, 0, 1, 1, 1, "R8 pulse cycle 1");
        step(1, 3'b100, 8'h00, 0, 0, 0, 0, 1, 1, 1, "R8 pulse cycle 2");
        step(1, 3'b100, 8'h00, 0, 0, 0, 0, 1, 1, 1, "R8 pulse cycle 3");
        step(1, 3'b100, 8'h00, 0, 0, 0, 1, 1, 1, 1, "R8 pulse ended");
        step(1, 3'b100, 8'h00, 0, 0, 1, 1, 1, 1, 1, "R8 read end");

        // Sample in the same cycle as the read start
        step(1, 3'b100, 8'h10, 1, 1, 0, 0, 1, 1, 1, "R8 same-cycle pulse 1");
        step(1, 3'b100, 8'h00, 0, 0, 0, 0, 1, 1, 1, "R8 same-cycle pulse 2");
        step(1, 3'b100, 8'h00, 0, 0, 0, 0, 1, 1, 1, "R8 same-cycle pulse 3");
        step(1, 3'b100, 8'h00, 0, 0, 1, 1, 1, 1, 1, "R8 same-cycle pulse ended");
        step(1, 3'b100, 8'h10, 1, 0, 0, 0, 1, 1, 0, "R7 level after read ended");

        // Reset in the middle of a pulse
        step(1, 3'b100, 8'h00, 0, 1, 0, 1, 1, 1, 1, "R7 acknowledge before reset");
        step(1, 3'b100, 8'h10, 1, 0, 0, 0, 1, 1, 1, "R8 pulse before reset");
        step(0, 3'b100, 8'h00, 0, 0, 0, 1, 1, 1, 1, "R10 reset ends pulse");
        step(1, 3'b100, 8'h00, 0, 0, 0, 1, 1, 1, 1, "R10 idle after reset");

        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule